// File: doc/BRIEF.md
# Flash Program/Erase Sequencer

This block runs program and erase operations on a byte-wide parallel flash that has an on-chip write state machine and a status byte. A client hands it one request at a time. A request either writes one byte or erases the block that holds a given address. The sequencer then works through the rest of the operation alone:

- it issues the command bus cycles;
- it polls the status byte until the device reports ready;
- it clears the status and decides whether the attempt succeeded;
- it retries when an attempt fails.

Every operation ends with the device back in read-array mode, and a one-cycle result pulse then reports success or error.

The request side is a valid/ready handshake. A request is taken on the clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low from that edge until the result pulse, so the client keeps a new request held on `req_valid` until the block is free. That is the only back-pressure. The result is a plain pulse and cannot be stalled. The flash side is a generic asynchronous bus with an address, separate write and read data, and active-high write and read strobes. Every delay is a parameter counted in clock cycles: the poll interval, the erase dwell, the settle time between erase attempts, and the setup, strobe and hold times of each bus cycle.

Top module: `flash_wsm_seq`

## Requirements
- R1: A request is accepted when `req_valid` and `req_ready` are both high. `req_erase`=1 selects a block erase and 0 selects a byte program. `req_ready` is low from the cycle after acceptance until the result pulse, and no bus strobe is active while `req_ready` is high.
- R2: Each program attempt writes 0x50 (clear status), then 0x40, then the data byte, all at the request address.
- R3: Each erase attempt writes 0x50, then 0x20, then 0xD0, all at the request address.
- R4: After the command writes the block reads the status byte at the request address. It repeats the read until bit 7 is set, and ignores the other bits of a status with bit 7 clear. The first read follows the last command strobe by at least ERASE_DWELL_CYC cycles for an erase and POLL_CYC cycles for a program. Repeated reads are at least POLL_CYC cycles apart.
- R5: Once a ready status has been read, 0x50 is written before anything else.
- R6: A program attempt fails when status bit 4 or bit 3 is set. Bit 5 alone does not fail it.
- R7: An erase attempt fails when bit 5 or bit 3 is set, or when bits 5 and 4 are both set. Bit 4 alone does not fail it.
- R8: After a failed program attempt the block writes 0xFF and reads the byte back. A value other than 0xFF ends the operation with an error. Otherwise it retries, and it reports an error after PROG_TRIES attempts.
- R9: After a failed erase attempt the block waits at least SETTLE_CYC cycles and retries. After ERASE_TRIES failed attempts it writes 0xFF and reports an error.
- R10: A successful attempt is followed by a 0xFF write and then a result without error. The last write before any result is 0xFF.
- R11: For every bus cycle the address (and, for a write, the data) is stable at least SETUP_CYC cycles before the strobe rises, during the strobe, and in the cycle after it falls. Each strobe is high for exactly PULSE_CYC cycles. The write and read strobes are never high together.
- R12: The result is a one-cycle `res_valid` pulse. `res_err` is high only with `res_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_erase | input | 1 | 1 = erase block, 0 = program byte |
| req_addr | input | AW | Target address |
| req_data | input | 8 | Byte to program |
| res_valid | output | 1 | Result pulse |
| res_err | output | 1 | Operation failed (valid with res_valid) |
| fl_addr | output | AW | Flash address |
| fl_dout | output | 8 | Flash write data |
| fl_din | input | 8 | Flash read data |
| fl_wr | output | 1 | Write strobe, active high |
| fl_rd | output | 1 | Read strobe, active high |

## Verification
The bench returns status bytes with bit 7 clear but error bits set. A sequencer that decoded before readiness would then fail a good attempt. The bench also uses status values that pass one operation and fail the other (bit 5 alone, bit 4 alone), so swapped or merged error masks change the result. Program retries are driven both into a non-erased read-back, which must stop at once, and through the full attempt budget with clean read-backs, which catches an off-by-one retry count. Every strobe is compared against a bench-built transaction list with minimum gaps, so a dwell, settle or poll wait that is too short shows up as an early strobe.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [3:0] {
    SQ_IDLE,
    SQ_CLR,
    SQ_CMD1,
    SQ_CMD2,
    SQ_WAIT,
    SQ_POLL,
    SQ_CLR2,
    SQ_ARRAY,
    SQ_RDBK
  } seq_state_e;

  typedef enum logic [1:0] {
    TL_OK,
    TL_RDBK,
    TL_ERR
  } tail_e;

  typedef enum logic [1:0] {
    BC_IDLE,
    BC_SETUP,
    BC_PULSE,
    BC_HOLD
  } bus_phase_e;

  // Device command codes
  localparam logic [7:0] FC_CLEAR_STATUS  = 8'h50;
  localparam logic [7:0] FC_READ_ARRAY    = 8'hFF;
  localparam logic [7:0] FC_PROG_SETUP    = 8'h40;
  localparam logic [7:0] FC_ERASE_SETUP   = 8'h20;
  localparam logic [7:0] FC_ERASE_CONFIRM = 8'hD0;

  // Status byte decoding
  localparam int         RDY_BIT        = 7;
  localparam logic [7:0] PROG_ERR_MASK  = 8'h18;
  localparam logic [7:0] ERASE_ERR_MASK = 8'h28;
  localparam logic [7:0] ERASE_SEQ_MASK = 8'h30;

endpackage

// File: rtl/fl_bus_cycle.sv
module fl_bus_cycle #(
  parameter int AW        = 20,
  parameter int SETUP_CYC = 1,
  parameter int PULSE_CYC = 2,
  parameter int HOLD_CYC  = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          rd,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic          done,
  output logic [7:0]    rdata,
  output logic [AW-1:0] fl_addr,
  output logic [7:0]    fl_dout,
  input  logic [7:0]    fl_din,
  output logic          fl_wr,
  output logic          fl_rd
);
  import flash_seq_pkg::*;

  localparam int MAX_A = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int MAX_C = (MAX_A > HOLD_CYC) ? MAX_A : HOLD_CYC;
  localparam int CW    = $clog2(MAX_C + 1);
  localparam logic [CW-1:0] SU_L = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] PW_L = CW'(PULSE_CYC - 1);
  localparam logic [CW-1:0] HD_L = CW'(HOLD_CYC - 1);

  bus_phase_e    ph;
  logic [CW-1:0] cnt;
  logic          is_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= BC_IDLE;
      cnt     <= '0;
      is_rd   <= 1'b0;
      fl_addr <= '0;
      fl_dout <= '0;
      rdata   <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (ph)
        BC_IDLE: begin
          if (start) begin
            ph      <= BC_SETUP;
            cnt     <= SU_L;
            is_rd   <= rd;
            fl_addr <= addr;
            if (!rd) fl_dout <= wdata;
          end
        end
        BC_SETUP: begin
          if (cnt == '0) begin
            ph  <= BC_PULSE;
            cnt <= PW_L;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        BC_PULSE: begin
          if (cnt == '0) begin
            ph  <= BC_HOLD;
            cnt <= HD_L;
            if (is_rd) rdata <= fl_din;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        BC_HOLD: begin
          if (cnt == '0) begin
            ph   <= BC_IDLE;
            done <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: ph <= BC_IDLE;
      endcase
    end
  end

  assign fl_wr = (ph == BC_PULSE) && !is_rd;
  assign fl_rd = (ph == BC_PULSE) && is_rd;

endmodule

// File: rtl/fl_wait_timer.sv
module fl_wait_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0) && !load;

endmodule

// File: rtl/fl_status_eval.sv
module fl_status_eval (
  input  logic [7:0] status,
  input  logic       erase,
  output logic       ready,
  output logic       fail
);
  import flash_seq_pkg::*;

  logic prog_bad, erase_bad;

  assign ready     = status[RDY_BIT];
  assign prog_bad  = |(status & PROG_ERR_MASK);
  assign erase_bad = (|(status & ERASE_ERR_MASK)) ||
                     ((status & ERASE_SEQ_MASK) == ERASE_SEQ_MASK);
  assign fail      = erase ? erase_bad : prog_bad;

endmodule

// File: rtl/flash_wsm_seq.sv
module flash_wsm_seq #(
  parameter int AW              = 20,
  parameter int SETUP_CYC       = 1,
  parameter int PULSE_CYC       = 2,
  parameter int HOLD_CYC        = 1,
  parameter int POLL_CYC        = 750,
  parameter int ERASE_DWELL_CYC = 50_000_000,
  parameter int SETTLE_CYC      = 150_000_000,
  parameter int PROG_TRIES      = 20,
  parameter int ERASE_TRIES     = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_erase,
  input  logic [AW-1:0] req_addr,
  input  logic [7:0]    req_data,
  output logic          res_valid,
  output logic          res_err,
  output logic [AW-1:0] fl_addr,
  output logic [7:0]    fl_dout,
  input  logic [7:0]    fl_din,
  output logic          fl_wr,
  output logic          fl_rd
);
  import flash_seq_pkg::*;

  localparam int TMAX_A = (POLL_CYC > ERASE_DWELL_CYC) ? POLL_CYC : ERASE_DWELL_CYC;
  localparam int TMAX   = (TMAX_A > SETTLE_CYC) ? TMAX_A : SETTLE_CYC;
  localparam int TW     = $clog2(TMAX + 1);
  localparam int NMAX   = (PROG_TRIES > ERASE_TRIES) ? PROG_TRIES : ERASE_TRIES;
  localparam int NW     = $clog2(NMAX + 1);

  localparam logic [TW-1:0] POLL_V   = TW'(POLL_CYC);
  localparam logic [TW-1:0] DWELL_V  = TW'(ERASE_DWELL_CYC);
  localparam logic [TW-1:0] SETTLE_V = TW'(SETTLE_CYC);
  localparam logic [NW-1:0] PT_LAST  = NW'(PROG_TRIES - 1);
  localparam logic [NW-1:0] ET_LAST  = NW'(ERASE_TRIES - 1);

  seq_state_e    st, wait_to;
  tail_e         tail;
  logic          op_erase;
  logic [AW-1:0] t_addr;
  logic [7:0]    t_data;
  logic [7:0]    status_q;
  logic [NW-1:0] att;
  logic          launched;
  logic          tmr_load;
  logic [TW-1:0] tmr_val;
  logic          tmr_expired;

  logic          bus_state, bus_start, bus_rd, bus_done;
  logic [7:0]    bus_wdata, bus_rdata;
  logic          st_ready, st_fail;
  logic          last_att;

  // Command selection per state
  always_comb begin
    bus_state = 1'b1;
    bus_rd    = 1'b0;
    bus_wdata = FC_CLEAR_STATUS;
    unique case (st)
      SQ_CLR, SQ_CLR2: bus_wdata = FC_CLEAR_STATUS;
      SQ_CMD1:         bus_wdata = op_erase ? FC_ERASE_SETUP : FC_PROG_SETUP;
      SQ_CMD2:         bus_wdata = op_erase ? FC_ERASE_CONFIRM : t_data;
      SQ_ARRAY:        bus_wdata = FC_READ_ARRAY;
      SQ_POLL, SQ_RDBK: bus_rd   = 1'b1;
      default:         bus_state = 1'b0;
    endcase
  end

  assign bus_start = bus_state && !launched;
  assign last_att  = op_erase ? (att == ET_LAST) : (att == PT_LAST);
  assign req_ready = (st == SQ_IDLE);

  fl_bus_cycle #(
    .AW(AW), .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC), .HOLD_CYC(HOLD_CYC)
  ) u_bus (
    .clk(clk), .rst_n(rst_n), .start(bus_start), .rd(bus_rd),
    .addr(t_addr), .wdata(bus_wdata), .done(bus_done), .rdata(bus_rdata),
    .fl_addr(fl_addr), .fl_dout(fl_dout), .fl_din(fl_din),
    .fl_wr(fl_wr), .fl_rd(fl_rd)
  );

  fl_wait_timer #(.W(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .val(tmr_val),
    .expired(tmr_expired)
  );

  fl_status_eval u_eval (
    .status(status_q), .erase(op_erase), .ready(st_ready), .fail(st_fail)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= SQ_IDLE;
      wait_to   <= SQ_POLL;
      tail      <= TL_OK;
      op_erase  <= 1'b0;
      t_addr    <= '0;
      t_data    <= '0;
      status_q  <= '0;
      att       <= '0;
      launched  <= 1'b0;
      tmr_load  <= 1'b0;
      tmr_val   <= '0;
      res_valid <= 1'b0;
      res_err   <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      res_err   <= 1'b0;
      tmr_load  <= 1'b0;
      if (bus_start)     launched <= 1'b1;
      else if (bus_done) launched <= 1'b0;

      unique case (st)
        SQ_IDLE: begin
          if (req_valid) begin
            op_erase <= req_erase;
            t_addr   <= req_addr;
            t_data   <= req_data;
            att      <= '0;
            st       <= SQ_CLR;
          end
        end
        SQ_CLR:  if (bus_done) st <= SQ_CMD1;
        SQ_CMD1: if (bus_done) st <= SQ_CMD2;
        SQ_CMD2: begin
          if (bus_done) begin
            st       <= SQ_WAIT;
            tmr_load <= 1'b1;
            tmr_val  <= op_erase ? DWELL_V : POLL_V;
            wait_to  <= SQ_POLL;
          end
        end
        SQ_WAIT: if (tmr_expired) st <= wait_to;
        SQ_POLL: begin
          if (bus_done) begin
            status_q <= bus_rdata;
            if (bus_rdata[RDY_BIT]) begin
              st <= SQ_CLR2;
            end else begin
              st       <= SQ_WAIT;
              tmr_load <= 1'b1;
              tmr_val  <= POLL_V;
              wait_to  <= SQ_POLL;
            end
          end
        end
        SQ_CLR2: begin
          if (bus_done) begin
            if (st_ready && !st_fail) begin
              st   <= SQ_ARRAY;
              tail <= TL_OK;
            end else if (!op_erase) begin
              st   <= SQ_ARRAY;
              tail <= TL_RDBK;
            end else if (last_att) begin
              st   <= SQ_ARRAY;
              tail <= TL_ERR;
            end else begin
              att      <= att + 1'b1;
              st       <= SQ_WAIT;
              tmr_load <= 1'b1;
              tmr_val  <= SETTLE_V;
              wait_to  <= SQ_CLR;
            end
          end
        end
        SQ_ARRAY: begin
          if (bus_done) begin
            if (tail == TL_RDBK) begin
              st <= SQ_RDBK;
            end else begin
              res_valid <= 1'b1;
              res_err   <= (tail == TL_ERR);
              st        <= SQ_IDLE;
            end
          end
        end
        SQ_RDBK: begin
          if (bus_done) begin
            if ((bus_rdata != FC_READ_ARRAY) || last_att) begin
              res_valid <= 1'b1;
              res_err   <= 1'b1;
              st        <= SQ_IDLE;
            end else begin
              att <= att + 1'b1;
              st  <= SQ_CLR;
            end
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/flash_wsm_seq_chk.sv
module flash_wsm_seq_chk #(
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          res_valid,
  input logic          res_err,
  input logic [AW-1:0] fl_addr,
  input logic [7:0]    fl_dout,
  input logic          fl_wr,
  input logic          fl_rd
);

  // R11
  strobes_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fl_wr && fl_rd));

  // R11
  wr_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_wr) |-> ($stable(fl_addr) && $stable(fl_dout)));

  // R11
  rd_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_rd) |-> $stable(fl_addr));

  // R11
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fl_wr) |-> ($stable(fl_addr) && $stable(fl_dout)));

  // R11
  strobe_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((fl_wr || fl_rd) && $past(fl_wr || fl_rd)) |-> $stable(fl_addr));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!fl_wr && !fl_rd));

  // R1
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R12
  res_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !$past(req_ready));

  // R12
  res_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R12
  err_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_err |-> res_valid);

  // R10
  array_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (fl_dout == 8'hFF));

endmodule

bind flash_wsm_seq flash_wsm_seq_chk #(.AW(AW)) u_chk (.*);

// File: tb/test_flash_wsm_seq.sv
module test_flash_wsm_seq;
  localparam int AW     = 16;
  localparam int SETUP  = 2;
  localparam int PULSE  = 2;
  localparam int HOLD   = 1;
  localparam int POLL   = 5;
  localparam int DWELL  = 40;
  localparam int SETTLE = 60;
  localparam int PT     = 20;
  localparam int ET     = 11;
  localparam int WDOG   = 150000;
  localparam logic [7:0] BUSY = 8'h78;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_erase = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0]    req_data = '0;
  logic          res_valid, res_err;
  logic [AW-1:0] fl_addr;
  logic [7:0]    fl_dout;
  logic [7:0]    fl_din = 8'h00;
  logic          fl_wr, fl_rd;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  // expected transaction list
  bit            q_rd[$];
  logic [AW-1:0] q_a[$];
  logic [7:0]    q_d[$];
  int            q_gap[$];
  string         q_tag[$];

  // per-attempt scenario script
  int         sc_n;
  int         sc_k[32];
  logic [7:0] sc_s[32];
  logic [7:0] sc_r[32];

  always #10 clk = ~clk;

  flash_wsm_seq #(
    .AW(AW), .SETUP_CYC(SETUP), .PULSE_CYC(PULSE), .HOLD_CYC(HOLD),
    .POLL_CYC(POLL), .ERASE_DWELL_CYC(DWELL), .SETTLE_CYC(SETTLE),
    .PROG_TRIES(PT), .ERASE_TRIES(ET)
  ) i_flash_wsm_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_erase(req_erase), .req_addr(req_addr), .req_data(req_data),
    .res_valid(res_valid), .res_err(res_err), .fl_addr(fl_addr),
    .fl_dout(fl_dout), .fl_din(fl_din), .fl_wr(fl_wr), .fl_rd(fl_rd)
  );

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic push(bit rd, logic [AW-1:0] a, logic [7:0] d, int gap, string tag);
    q_rd.push_back(rd);
    q_a.push_back(a);
    q_d.push_back(d);
    q_gap.push_back(gap);
    q_tag.push_back(tag);
  endtask

  // Build the expected bus traffic from the requirements
  task automatic build(bit erase, logic [AW-1:0] a, logic [7:0] d, output bit err);
    int lim;
    lim = erase ? ET : PT;
    err = 1'b1;
    for (int i = 0; i < sc_n; i++) begin
      bit fail_now;
      bit last;
      last = (i == lim - 1);
      if (erase) begin
        push(1'b0, a, 8'h50, (i > 0) ? SETTLE : 0, "R3");
        push(1'b0, a, 8'h20, 0, "R3");
        push(1'b0, a, 8'hD0, 0, "R3");
      end else begin
        push(1'b0, a, 8'h50, 0, "R2");
        push(1'b0, a, 8'h40, 0, "R2");
        push(1'b0, a, d, 0, "R2");
      end
      for (int j = 0; j <= sc_k[i]; j++)
        push(1'b1, a, (j == sc_k[i]) ? sc_s[i] : BUSY,
             (j == 0) ? (erase ? DWELL : POLL) : POLL, "R4");
      push(1'b0, a, 8'h50, 0, "R5");
      if (erase)
        fail_now = ((sc_s[i] & 8'h28) != 0) || ((sc_s[i] & 8'h30) == 8'h30);
      else
        fail_now = ((sc_s[i] & 8'h18) != 0);
      if (!fail_now) begin
        push(1'b0, a, 8'hFF, 0, "R10");
        err = 1'b0;
        return;
      end
      if (!erase) begin
        push(1'b0, a, 8'hFF, 0, "R8");
        push(1'b1, a, sc_r[i], 0, "R8");
        if (sc_r[i] != 8'hFF || last) return;
      end else if (last) begin
        push(1'b0, a, 8'hFF, 0, "R9");
        return;
      end
    end
  endtask

  task automatic set_att(int i, int k, logic [7:0] s, logic [7:0] r);
    sc_k[i] = k;
    sc_s[i] = s;
    sc_r[i] = r;
  endtask

  task automatic run_op(bit erase, logic [AW-1:0] a, logic [7:0] d, string tag);
    bit exp_err;
    int t0;
    build(erase, a, d, exp_err);
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready before request", req_ready, 1);
    req_valid = 1'b1;
    req_erase = erase;
    req_addr  = a;
    req_data  = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R1", "ready after accept", req_ready, 0);
    t0 = cyc;
    while (!res_valid && (cyc - t0) < WDOG) @(negedge clk);
    if (!res_valid) begin
      chk(1'b0, tag, "watchdog expired", 0, 1);
    end else begin
      chk(res_err == exp_err, tag, "result error flag", res_err, exp_err);
      chk(q_rd.size() == 0, tag, "bus cycles left unissued", q_rd.size(), 0);
      @(negedge clk);
      chk(res_valid == 1'b0, "R12", "result pulse width", res_valid, 0);
    end
    q_rd.delete(); q_a.delete(); q_d.delete(); q_gap.delete(); q_tag.delete();
  endtask

  // Bus responder and per-transaction comparison
  bit            wr_prev = 1'b0, rd_prev = 1'b0;
  logic [AW-1:0] addr_prev = '0, addr_cap = '0;
  logic [7:0]    dout_prev = '0;
  int            stab = 0, plen = 0, last_rise = 0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      bit rise, fall;
      rise = (fl_wr && !wr_prev) || (fl_rd && !rd_prev);
      fall = (!fl_wr && wr_prev) || (!fl_rd && rd_prev);
      if (fl_addr != addr_prev || fl_dout != dout_prev) stab = 0;
      else stab++;
      if (fl_wr && fl_rd) chk(1'b0, "R11", "both strobes", 1, 0);
      if (rise) begin
        chk(stab >= SETUP, "R11", "setup cycles", stab, SETUP);
        addr_cap = fl_addr;
        plen = 1;
        if (q_rd.size() == 0) begin
          chk(1'b0, "R2", "unexpected bus cycle", fl_addr, 0);
        end else begin
          bit e_rd;
          logic [AW-1:0] e_a;
          logic [7:0] e_d;
          int e_gap;
          string e_tag;
          e_rd = q_rd.pop_front();
          e_a = q_a.pop_front();
          e_d = q_d.pop_front();
          e_gap = q_gap.pop_front();
          e_tag = q_tag.pop_front();
          chk(fl_rd == e_rd, e_tag, "cycle kind (1=read)", fl_rd, e_rd);
          chk(fl_addr == e_a, e_tag, "address", fl_addr, e_a);
          if (!e_rd) chk(fl_dout == e_d, e_tag, "write data", fl_dout, e_d);
          else fl_din = e_d;
          if (e_gap > 0)
            chk((cyc - last_rise) >= e_gap, (e_gap == SETTLE) ? "R9" : "R4",
                "gap since previous strobe", cyc - last_rise, e_gap);
        end
        last_rise = cyc;
      end else if (fl_wr || fl_rd) begin
        plen++;
        if (fl_addr != addr_cap) chk(1'b0, "R11", "address moved in strobe", fl_addr, addr_cap);
      end
      if (fall) chk(plen == PULSE, "R11", "strobe width", plen, PULSE);
    end
    wr_prev   = fl_wr;
    rd_prev   = fl_rd;
    addr_prev = fl_addr;
    dout_prev = fl_dout;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready in reset", req_ready, 1);
    chk(res_valid == 1'b0, "R12", "result in reset", res_valid, 0);
    chk(!fl_wr && !fl_rd, "R11", "strobes in reset", fl_wr | fl_rd, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // program, first attempt good
    sc_n = 1; set_att(0, 0, 8'h80, 8'hFF);
    run_op(1'b0, 16'h1234, 8'h5A, "R2");
    // program, busy polls and harmless low bits
    sc_n = 1; set_att(0, 3, 8'h87, 8'hFF);
    run_op(1'b0, 16'h0007, 8'hC3, "R4");
    // program, bit 5 alone is not a program error
    sc_n = 1; set_att(0, 1, 8'hA0, 8'hFF);
    run_op(1'b0, 16'hBEEF, 8'h01, "R6");
    // program, fail with erased read-back, then pass
    sc_n = 2; set_att(0, 0, 8'h90, 8'hFF); set_att(1, 2, 8'h80, 8'hFF);
    run_op(1'b0, 16'h4000, 8'h3C, "R8");
    // program, fail with non-erased read-back aborts
    sc_n = 1; set_att(0, 0, 8'h88, 8'h7F);
    run_op(1'b0, 16'h00FF, 8'h7E, "R8");
    // program, every attempt fails
    sc_n = PT;
    for (int i = 0; i < PT; i++) set_att(i, 0, 8'h98, 8'hFF);
    run_op(1'b0, 16'hFFFE, 8'h11, "R8");
    // erase, good after busy polls
    sc_n = 1; set_att(0, 2, 8'h80, 8'hFF);
    run_op(1'b1, 16'h8000, 8'h00, "R3");
    // erase, bit 3 fail, bits 5+4 fail, bit 4 alone passes
    sc_n = 3; set_att(0, 0, 8'h88, 8'hFF); set_att(1, 1, 8'hB0, 8'hFF);
    set_att(2, 0, 8'h90, 8'hFF);
    run_op(1'b1, 16'h2345, 8'h00, "R7");
    // erase, every attempt fails
    sc_n = ET;
    for (int i = 0; i < ET; i++) set_att(i, 0, 8'hA0, 8'hFF);
    run_op(1'b1, 16'h6001, 8'h00, "R9");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule